// File: doc/BRIEF.md
# UART Interrupt Status and Control Unit

This block holds the interrupt identification logic of a high-speed UART. Six event sources are gathered into one 7-bit status word. Three of them are error events (framing error, break, receive overrun) and are caught as single-cycle pulses. One is the transmit request, which is generated when the transmit FIFO drains past a programmable threshold. These four bits stay set until software writes 1 to them. The receive trigger bit and the receive timeout bit are different: they mirror live receive-FIFO conditions, so software cannot clear them.

A control word gives a separate enable to each of the three groups: transmit, receive and error. It also holds a 2-bit transmit threshold code and a bit that forces the serial output low to send a break. A single interrupt line is registered from the status word masked by the group enables. Software can also raise a transmit request directly by writing a strobe bit. The serializers, the FIFO storage and the bus fabric lie outside this block.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, the latched status bits are 0, the control word is 0 and `irq_o` is 0. `tx_pin_o` follows `tx_serial_i`.
- R2: Status bit 0 (transmit request) sets on the cycle in which `tx_level_i` moves from above the threshold to at or below it. A level that stays at or below the threshold does not set the bit again.
- R3: Control bits [1:0] select the transmit threshold: code 0 gives 0 (empty), code 1 gives 4, code 2 gives 8 and code 3 gives 16 characters.
- R4: A status write with 1 in bit 0, 3, 4 or 5 clears that latched bit. A 0 in those positions leaves the bit unchanged.
- R5: The latched bits are framing error (bit 3, from `frame_err_i`), break (bit 4, from `break_det_i`) and overrun (bit 5, from `overrun_i`). When an event arrives in the same cycle as a clear of its bit, the event wins and the bit stays set.
- R6: Status bits 1 and 2 show `rx_trig_i` and `rx_idle_i` as they are, and status writes have no effect on them.
- R7: A status write with bit 6 set sets the transmit request bit. Status bit 6 always reads 0.
- R8: `irq_o` is registered and changes one cycle after its inputs change. It is the OR of three terms: bit 0 with control bit 5, bits 1 or 2 with control bit 6, and any of bits 3 to 5 with control bit 7.
- R9: While control bit 8 is set, `tx_pin_o` is held at 0.
- R10: The control word stores bits [1:0] and [8:5]. All its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects status, 1 selects control |
| wr_data | input | 16 | Write data |
| tx_level_i | input | 8 | Current transmit FIFO fill count |
| rx_trig_i | input | 1 | Receive FIFO is at or above its trigger level |
| rx_idle_i | input | 1 | Receive timeout condition |
| frame_err_i | input | 1 | Framing error event pulse |
| break_det_i | input | 1 | Break detected event pulse |
| overrun_i | input | 1 | Receive overrun event pulse |
| tx_serial_i | input | 1 | Serial data from the transmitter |
| status_o | output | 7 | Interrupt identification word |
| ctrl_o | output | 16 | Control word readback |
| irq_o | output | 1 | Interrupt request |
| tx_pin_o | output | 1 | Serial output pin |

## Verification
A fault in a latched bit shows up on `status_o` in the cycle right after the event or write that should have changed it, and on `irq_o` one cycle after that. A fault in the threshold edge detector shows up in one of two ways: the request fails to appear at the exact crossing level, or it appears again while the level stays low, so the bench steps the level across each threshold one count at a time. Mask and break faults appear directly on `irq_o` and `tx_pin_o` under a fixed status.

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int LEVEL_W = 8,
  parameter int DATA_W  = 16,
  parameter int TH_1    = 4,
  parameter int TH_2    = 8,
  parameter int TH_3    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [LEVEL_W-1:0] tx_level_i,
  input  logic               rx_trig_i,
  input  logic               rx_idle_i,
  input  logic               frame_err_i,
  input  logic               break_det_i,
  input  logic               overrun_i,
  input  logic               tx_serial_i,
  output logic [6:0]         status_o,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic               irq_o,
  output logic               tx_pin_o
);

  localparam int B_TXREQ = 0;
  localparam int B_FE    = 3;
  localparam int B_BRK   = 4;
  localparam int B_OVR   = 5;
  localparam int B_TXSET = 6;
  localparam int C_TXEN  = 5;
  localparam int C_RXEN  = 6;
  localparam int C_ERREN = 7;
  localparam int C_BRK   = 8;

  logic [1:0] thr_code;
  logic       en_tx, en_rx, en_err, force_brk;
  logic       tx_req, fe_q, brk_q, ovr_q;
  logic       below, below_q;
  logic [LEVEL_W-1:0] thr;

  wire st_wr   = wr_en && !wr_sel;
  wire ctl_wr  = wr_en &&  wr_sel;

  always_comb begin
    case (thr_code)
      2'd0:    thr = '0;
      2'd1:    thr = LEVEL_W'(TH_1);
      2'd2:    thr = LEVEL_W'(TH_2);
      default: thr = LEVEL_W'(TH_3);
    endcase
  end

  assign below = (tx_level_i <= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_code  <= '0;
      en_tx     <= 1'b0;
      en_rx     <= 1'b0;
      en_err    <= 1'b0;
      force_brk <= 1'b0;
    end else if (ctl_wr) begin
      thr_code  <= wr_data[1:0];
      en_tx     <= wr_data[C_TXEN];
      en_rx     <= wr_data[C_RXEN];
      en_err    <= wr_data[C_ERREN];
      force_brk <= wr_data[C_BRK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      below_q <= 1'b1;
      tx_req  <= 1'b0;
      fe_q    <= 1'b0;
      brk_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      below_q <= below;
      if ((below && !below_q) || (st_wr && wr_data[B_TXSET]))
        tx_req <= 1'b1;
      else if (st_wr && wr_data[B_TXREQ])
        tx_req <= 1'b0;
      if (frame_err_i)                     fe_q  <= 1'b1;
      else if (st_wr && wr_data[B_FE])     fe_q  <= 1'b0;
      if (break_det_i)                     brk_q <= 1'b1;
      else if (st_wr && wr_data[B_BRK])    brk_q <= 1'b0;
      if (overrun_i)                       ovr_q <= 1'b1;
      else if (st_wr && wr_data[B_OVR])    ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= (tx_req && en_tx)
                       || ((rx_trig_i || rx_idle_i) && en_rx)
                       || ((fe_q || brk_q || ovr_q) && en_err);
  end

  assign status_o = {1'b0, ovr_q, brk_q, fe_q, rx_idle_i, rx_trig_i, tx_req};

  always_comb begin
    ctrl_o          = '0;
    ctrl_o[1:0]     = thr_code;
    ctrl_o[C_TXEN]  = en_tx;
    ctrl_o[C_RXEN]  = en_rx;
    ctrl_o[C_ERREN] = en_err;
    ctrl_o[C_BRK]   = force_brk;
  end

  assign tx_pin_o = tx_serial_i && !force_brk;

  p_txset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wr_data[B_TXSET]) |=> status_o[0]);

  p_w1c_fe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && wr_data[B_FE] && !frame_err_i) |=> !status_o[3]);

  p_hold_brk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4] && !(st_wr && wr_data[B_BRK])) |=> status_o[4]);

  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[7:5] == 3'b000) |=> !irq_o);

  p_break_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[8] |-> !tx_pin_o);

  p_noset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_o[0] && below_q && below && !(st_wr && wr_data[B_TXSET])) |=> !status_o[0]);

endmodule

// File: tb/tb_uart_irq_status.sv
module tb_uart_irq_status;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  tx_level_i = 8'd30;
  logic        rx_trig_i = 0, rx_idle_i = 0, frame_err_i = 0, break_det_i = 0, overrun_i = 0;
  logic        tx_serial_i = 1'b1;
  logic [6:0]  status_o;
  logic [15:0] ctrl_o;
  logic        irq_o, tx_pin_o;

  int checks = 0, failures = 0;
  bit done = 0;
  int          q_sig[$];
  logic [15:0] q_exp[$];
  string       q_req[$];

  uart_irq_status dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tx_level_i(tx_level_i), .rx_trig_i(rx_trig_i), .rx_idle_i(rx_idle_i),
    .frame_err_i(frame_err_i), .break_det_i(break_det_i), .overrun_i(overrun_i),
    .tx_serial_i(tx_serial_i), .status_o(status_o), .ctrl_o(ctrl_o),
    .irq_o(irq_o), .tx_pin_o(tx_pin_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares queued expectations at the falling edge
  initial forever begin
    @(negedge clk);
    while (q_sig.size() > 0) begin
      automatic int s = q_sig.pop_front();
      automatic logic [15:0] e = q_exp.pop_front();
      automatic string r = q_req.pop_front();
      automatic logic [15:0] a;
      case (s)
        0: a = {9'd0, status_o};
        1: a = ctrl_o;
        2: a = {15'd0, irq_o};
        default: a = {15'd0, tx_pin_o};
      endcase
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s sig=%0d actual=%h expected=%h", r, s, a, e);
      end
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic sync(); @(negedge clk); #1; endtask
  task automatic expect_(int s, logic [15:0] v, string r);
    q_sig.push_back(s); q_exp.push_back(v); q_req.push_back(r);
  endtask
  task automatic wr(logic sel, logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; cyc(); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    sync();
    expect_(0, 16'h0000, "R1 status"); expect_(1, 16'h0000, "R1 ctrl");
    expect_(2, 16'h0000, "R1 irq");    expect_(3, 16'h0001, "R1 txpin");
    sync();

    // R10 control readback, threshold code 2 (8), all enables
    wr(1, 16'hFCE2);
    expect_(1, 16'h00E2, "R10 ctrl fields"); sync();
    cyc(); wr(0, 16'h0001); sync();

    // R3 code 2: 9 does not set, 8 sets
    tx_level_i = 9; cyc(); expect_(0, 16'h0000, "R3 above thr8"); sync();
    tx_level_i = 8; cyc(); expect_(0, 16'h0001, "R2 R3 crossing 8"); sync();
    cyc(); expect_(2, 16'h0001, "R8 tx irq"); sync();
    wr(0, 16'h0001); expect_(0, 16'h0000, "R4 clear txreq"); sync();
    cyc(); expect_(0, 16'h0000, "R2 no re-latch"); expect_(2, 16'h0000, "R8 irq drops"); sync();

    // R3 code 0: empty
    tx_level_i = 30; cyc(); sync();
    wr(1, 16'h00E0); sync();
    tx_level_i = 1; cyc(); expect_(0, 16'h0000, "R3 level1 code0"); sync();
    tx_level_i = 0; cyc(); expect_(0, 16'h0001, "R3 empty code0"); sync();
    wr(0, 16'h0001); sync();

    // R3 code 3: 16
    tx_level_i = 30; cyc(); sync();
    wr(1, 16'h00E3); sync();
    tx_level_i = 17; cyc(); expect_(0, 16'h0000, "R3 level17 code3"); sync();
    tx_level_i = 16; cyc(); expect_(0, 16'h0001, "R3 level16 code3"); sync();
    wr(0, 16'h0001); sync();
    // R3 code 1: 4
    tx_level_i = 30; cyc(); sync();
    wr(1, 16'h00E1); sync();
    tx_level_i = 5; cyc(); expect_(0, 16'h0000, "R3 level5 code1"); sync();
    tx_level_i = 4; cyc(); expect_(0, 16'h0001, "R3 level4 code1"); sync();
    wr(0, 16'h0001); expect_(0, 16'h0000, "R4 clear again"); sync();

    // R5 error events
    frame_err_i = 1; cyc(); frame_err_i = 0; expect_(0, 16'h0008, "R5 framing latch"); sync();
    cyc(); expect_(2, 16'h0001, "R8 err irq"); sync();
    wr(0, 16'h0000); expect_(0, 16'h0008, "R4 zero write no effect"); sync();
    break_det_i = 1; wr(0, 16'h0008); break_det_i = 0;
    expect_(0, 16'h0010, "R4 R5 fe cleared brk set"); sync();
    break_det_i = 1; wr(0, 16'h0010); break_det_i = 0;
    expect_(0, 16'h0010, "R5 event beats clear"); sync();
    overrun_i = 1; cyc(); overrun_i = 0; expect_(0, 16'h0030, "R5 overrun latch"); sync();
    wr(0, 16'h0030); expect_(0, 16'h0000, "R4 clear brk ovr"); sync();
    cyc(); expect_(2, 16'h0000, "R8 err irq gone"); sync();

    // R6 live receive bits
    rx_trig_i = 1; wr(0, 16'h0006); expect_(0, 16'h0002, "R6 trig not cleared"); sync();
    cyc(); expect_(2, 16'h0001, "R8 rx irq"); sync();
    rx_trig_i = 0; rx_idle_i = 1; cyc(); expect_(0, 16'h0004, "R6 timeout live"); sync();

    // R8 mask all
    wr(1, 16'h0000); sync();
    cyc(); expect_(2, 16'h0000, "R8 masked"); sync();
    rx_idle_i = 0;

    // R7 software set
    wr(0, 16'h0040); expect_(0, 16'h0001, "R7 set via bit6"); sync();
    wr(0, 16'h0041); expect_(0, 16'h0001, "R7 set beats clear"); sync();
    wr(0, 16'h0001); sync();

    // R9 break
    wr(1, 16'h0100); expect_(3, 16'h0000, "R9 pin forced low");
    expect_(1, 16'h0100, "R10 brk readback"); sync();
    wr(1, 16'h0000); expect_(3, 16'h0001, "R9 pin released"); sync();

    sync();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule